// File: doc/BRIEF.md
# MDIO Management Frame Master

This block turns a single-cycle command into a complete serial management frame toward an Ethernet PHY. A command carries a read/write selector, a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit value. The block drives the management clock, the serial data output and its output enable. It samples the serial data input, and at the end it returns a one-cycle completion pulse together with the 16-bit value read.

A frame is a fixed sequence of bit slots sent most significant bit first. It opens with a run of 32 ones that lets the PHY synchronise. After that come the start pattern, the opcode, the two address fields, a released turnaround and the data field, and a final released clock closes the frame. A read is 64 clock periods long and has one turnaround slot. A write is 65 periods long and has two turnaround slots. The bit period is two equal halves, and the length of each half in system clocks is a parameter. The default of 20 keeps the management clock at 2.5 MHz when the system clock is 100 MHz. Reset is asserted asynchronously and active low, and its release is synchronised inside the block.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is running, `mdc_o`, `mdo_o`, `mdo_oe_o`, `busy_o`, `done_o` and `rd_data_o` are all 0.
- R2: Slots 0 to 31 of every frame have `mdo_oe_o`=1 and `mdo_o`=1.
- R3: Slots 32 and 33 carry 0 and then 1. Slots 34 and 35 carry 1,0 for a read and 0,1 for a write, with `mdo_oe_o`=1 in all four slots.
- R4: Slots 36 to 40 carry `phy_addr_i` MSB first, and slots 41 to 45 carry `reg_addr_i` MSB first, with the output enabled.
- R5: A write (`write_i`=1) has `mdo_oe_o`=0 and `mdo_o`=0 in slots 46 and 47. Slots 48 to 63 carry `wdata_i` MSB first with the output enabled, and slot 64 is released. The frame has exactly 65 slots.
- R6: A read (`write_i`=0) has slots 46 to 63 released (`mdo_oe_o`=0, `mdo_o`=0). The frame has exactly 64 slots.
- R7: Each slot is HALF_DIV system clocks with `mdc_o` low followed by HALF_DIV clocks with `mdc_o` high, and `mdo_o`/`mdo_oe_o` stay constant within the slot. `done_o` rises exactly slots×2×HALF_DIV clocks after the edge that accepts the command.
- R8: The block samples `mdi_i` only in the last system clock of each high half. Only slots 47 to 62 of a read are kept, MSB first, and a value on `mdi_i` at any other moment has no effect on the result.
- R9: `busy_o` goes to 1 on the edge after `start_i` is accepted and stays 1 until `done_o`. A `start_i` seen while `busy_o`=1 is ignored, including in the frame's final clock. A `start_i` in the cycle in which `done_o` is high is accepted.
- R10: `done_o` is a one-cycle pulse. During that cycle `rd_data_o` holds the captured read value after a read and 0 after a write. In every other cycle it is 0.
- R11: When a frame ends, the outputs go back to idle: clock low, data low and output disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, taken when idle |
| write_i | input | 1 | 1 = write frame, 0 = read frame |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register number |
| wdata_i | input | 16 | Write value |
| mdi_i | input | 1 | Serial data from the PHY |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Serial data toward the PHY |
| mdo_oe_o | output | 1 | Output enable for the data line |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 16 | Read result, valid while `done_o` is high |

## Verification
A new command can arrive in the same cycle in which the sequencer finishes the last high half of a frame. The bench raises `start_i` in exactly that final busy cycle. It then checks that `done_o` appears on schedule, that `busy_o` stays low afterwards and that no further clock edges appear on `mdc_o`. A second test raises `start_i` in the cycle in which `done_o` is high and expects a new frame to begin at once. A third test changes `mdi_i` inside each high half. Its final value is only settled in the last system clock, so the captured word is correct only when the block samples at that point.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int IDX_W      = 7;
  localparam int PRE_LEN    = 32;
  localparam int SOF_POS    = PRE_LEN;
  localparam int OPC_POS    = SOF_POS + 2;
  localparam int PHY_POS    = OPC_POS + 2;
  localparam int REG_POS    = PHY_POS + ADDR_W;
  localparam int TA_POS     = REG_POS + ADDR_W;
  localparam int RD_DAT_POS = TA_POS + 1;
  localparam int WR_DAT_POS = TA_POS + 2;
  localparam int RD_LAST    = RD_DAT_POS + DATA_W;
  localparam int WR_LAST    = WR_DAT_POS + DATA_W;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] rsel;
    logic [DATA_W-1:0] wd;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_halfdiv.sv
module mdio_halfdiv #(
  parameter int HALF_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  mdio_cmd_t            cmd_i,
  input  logic                 tick_i,
  output logic                 busy_o,
  output logic                 high_o,
  output logic [IDX_W-1:0]     idx_o,
  output mdio_cmd_t            cmd_o,
  output logic                 accept_o,
  output logic                 sample_o,
  output logic                 done_o
);
  logic             busy_q, busy_d, hi_q, hi_d, done_q, done_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_idx;
  mdio_cmd_t        cmd_q;

  assign accept_o = start_i && !busy_q;
  assign sample_o = busy_q && hi_q && tick_i;
  assign last_idx = cmd_q.wr ? IDX_W'(WR_LAST) : IDX_W'(RD_LAST);

  always_comb begin
    busy_d = busy_q;
    hi_d   = hi_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (accept_o) begin
      busy_d = 1'b1;
      hi_d   = 1'b0;
      idx_d  = '0;
    end else if (busy_q && tick_i) begin
      if (!hi_q) begin
        hi_d = 1'b1;
      end else if (idx_q == last_idx) begin
        busy_d = 1'b0;
        hi_d   = 1'b0;
        idx_d  = '0;
        done_d = 1'b1;
      end else begin
        hi_d  = 1'b0;
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hi_q   <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      hi_q   <= hi_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd_q <= '0;
    else if (accept_o) cmd_q <= cmd_i;
  end

  assign busy_o = busy_q;
  assign high_o = hi_q;
  assign idx_o  = idx_q;
  assign cmd_o  = cmd_q;
  assign done_o = done_q;

  // R6
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> idx_q <= IDX_W'(WR_LAST));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/mdio_framegen.sv
module mdio_framegen
  import mdio_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  mdio_cmd_t        cmd_i,
  output logic             oe_o,
  output logic             bit_o,
  output logic             cap_o
);
  logic [IDX_W-1:0] off;

  always_comb begin
    oe_o  = 1'b1;
    bit_o = 1'b1;
    cap_o = 1'b0;
    off   = '0;
    if (idx_i < IDX_W'(SOF_POS)) begin
      bit_o = 1'b1;
    end else if (idx_i < IDX_W'(OPC_POS)) begin
      bit_o = (idx_i == IDX_W'(SOF_POS + 1));
    end else if (idx_i < IDX_W'(PHY_POS)) begin
      bit_o = (idx_i == IDX_W'(OPC_POS)) ? !cmd_i.wr : cmd_i.wr;
    end else if (idx_i < IDX_W'(REG_POS)) begin
      off   = IDX_W'(REG_POS - 1) - idx_i;
      bit_o = cmd_i.phy[off[2:0]];
    end else if (idx_i < IDX_W'(TA_POS)) begin
      off   = IDX_W'(TA_POS - 1) - idx_i;
      bit_o = cmd_i.rsel[off[2:0]];
    end else if (cmd_i.wr && idx_i >= IDX_W'(WR_DAT_POS) && idx_i < IDX_W'(WR_LAST)) begin
      off   = IDX_W'(WR_LAST - 1) - idx_i;
      bit_o = cmd_i.wd[off[3:0]];
    end else begin
      oe_o  = 1'b0;
      bit_o = 1'b0;
      cap_o = !cmd_i.wr && idx_i >= IDX_W'(RD_DAT_POS) && idx_i < IDX_W'(RD_LAST);
    end
  end
endmodule

// File: rtl/mdio_capture.sv
module mdio_capture
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              mdi_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] rd_o
);
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (clear_i)      sh_d = '0;
    else if (shift_i) sh_d = {sh_q[DATA_W-2:0], mdi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rd_o = done_i ? sh_q : '0;

  // R10
  rd_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |-> rd_o == '0);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        write_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  input  logic        mdi_i,
  output logic        mdc_o,
  output logic        mdo_o,
  output logic        mdo_oe_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rd_data_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_q;
  logic             tick, busy, high, accept, sample, done, oe_b, bit_b, cap_b;
  logic [IDX_W-1:0] idx;
  mdio_cmd_t        cmd_in, cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  assign cmd_in = '{wr: write_i, phy: phy_addr_i, rsel: reg_addr_i, wd: wdata_i};

  mdio_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_q), .run_i(busy), .tick_o(tick)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_q), .start_i(start_i), .cmd_i(cmd_in), .tick_i(tick),
    .busy_o(busy), .high_o(high), .idx_o(idx), .cmd_o(cmd_q),
    .accept_o(accept), .sample_o(sample), .done_o(done)
  );

  mdio_framegen u_gen (
    .idx_i(idx), .cmd_i(cmd_q), .oe_o(oe_b), .bit_o(bit_b), .cap_o(cap_b)
  );

  mdio_capture u_cap (
    .clk(clk), .rst_n(rst_q), .clear_i(accept), .shift_i(sample && cap_b),
    .mdi_i(mdi_i), .done_i(done), .rd_o(rd_data_o)
  );

  assign mdc_o    = busy && high;
  assign mdo_o    = busy && bit_b;
  assign mdo_oe_o = busy && oe_b;
  assign busy_o   = busy;
  assign done_o   = done;

  // R7
  high_stable_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdo_o) && $stable(mdo_oe_o)));

  // R9
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(busy_o) |-> $past(start_i));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> (!busy_o && !mdc_o && !mdo_o && !mdo_oe_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !busy_o |-> (!mdc_o && !mdo_oe_o));
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int H = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0, mdi = 1'b0;
  logic [4:0] phy = '0, rsel = '0;
  logic [15:0] wd = '0;
  logic mdc, mdo, oe, busy, done;
  logic [15:0] rd;

  int checks = 0, fails = 0;
  int k = 0;
  logic cur_rd = 1'b0;
  logic [15:0] cur_resp = '0;
  logic rec_oe [0:79];
  logic rec_mdo [0:79];
  logic exp_oe [0:79];
  logic exp_mdo [0:79];
  int exp_n = 0;

  mdio_master #(.HALF_DIV(H)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .write_i(wr),
    .phy_addr_i(phy), .reg_addr_i(rsel), .wdata_i(wd), .mdi_i(mdi),
    .mdc_o(mdc), .mdo_o(mdo), .mdo_oe_o(oe), .busy_o(busy), .done_o(done),
    .rd_data_o(rd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model: records each slot, drives a wrong value first and the
  // correct one only in the last system clock of the high half (R8)
  always @(posedge mdc) begin
    logic v;
    if (k < 80) begin
      rec_oe[k]  = oe;
      rec_mdo[k] = mdo;
    end
    v = (cur_rd && k >= 47 && k <= 62) ? cur_resp[62 - k] : k[0];
    mdi = ~v;
    repeat (H - 1) @(posedge clk);
    #1 mdi = v;
    k = k + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic e, input logic b);
    exp_oe[exp_n]  = e;
    exp_mdo[exp_n] = b;
    exp_n++;
  endtask

  task automatic build(input logic w, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d);
    exp_n = 0;
    for (int i = 0; i < 32; i++) push(1, 1);
    push(1, 0); push(1, 1);
    if (w) begin push(1, 0); push(1, 1); end
    else   begin push(1, 1); push(1, 0); end
    for (int i = 4; i >= 0; i--) push(1, p[i]);
    for (int i = 4; i >= 0; i--) push(1, r[i]);
    if (w) begin
      push(0, 0); push(0, 0);
      for (int i = 15; i >= 0; i--) push(1, d[i]);
      push(0, 0);
    end else begin
      for (int i = 0; i < 18; i++) push(0, 0);
    end
  endtask

  task automatic launch(input logic w, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] d, input logic [15:0] resp);
    wr = w; phy = p; rsel = r; wd = d;
    cur_rd = !w; cur_resp = resp; k = 0;
    build(w, p, r, d);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
  endtask

  // called one step after the accepting edge; returns in the done cycle
  task automatic finish(input logic w, input logic [15:0] resp, input bit inject);
    int n = 0, total, e_pre = 0, e_sof = 0, e_adr = 0, e_tail = 0;
    total = exp_n * 2 * H;
    while (!done && n < total + 20) begin
      @(posedge clk); #1;
      n++;
      start = 1'b0;
      if (inject && (n == 100 || n == total - 1)) begin
        start = 1'b1; wr = ~wr; phy = ~phy; rsel = ~rsel; wd = ~wd;
      end
    end
    start = 1'b0;
    chk(n == total, "R7 frame length", n, total);
    chk(k == exp_n, w ? "R5 slot count" : "R6 slot count", k, exp_n);
    for (int i = 0; i < exp_n && i < 80; i++) begin
      if (rec_oe[i] !== exp_oe[i] || rec_mdo[i] !== exp_mdo[i]) begin
        if (i < 32) e_pre++;
        else if (i < 36) e_sof++;
        else if (i < 46) e_adr++;
        else e_tail++;
      end
    end
    chk(e_pre == 0, "R2 preamble slots", e_pre, 0);
    chk(e_sof == 0, "R3 start/opcode slots", e_sof, 0);
    chk(e_adr == 0, "R4 address slots", e_adr, 0);
    chk(e_tail == 0, w ? "R5 write tail slots" : "R6 read tail slots", e_tail, 0);
    chk(done && !busy, "R9 done ends busy", {done, busy}, 2);
    chk(!mdc && !mdo && !oe, "R11 idle at done", {mdc, mdo, oe}, 0);
    if (w) chk(rd == 16'h0, "R10 write result zero", rd, 0);
    else   chk(rd == resp, "R8 R10 read result", rd, resp);
  endtask

  task automatic after_idle();
    int k0;
    k0 = k;
    @(posedge clk); #1;
    chk(!done && rd == 16'h0, "R10 pulse ends", {done, rd}, 0);
    repeat (2 * H + 2) @(posedge clk);
    #1;
    chk(!busy && !mdc && !oe && !mdo, "R9 R1 stays idle", {busy, mdc, oe, mdo}, 0);
    chk(k == k0, "R9 no extra clocks", k, k0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] resp, d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk({mdc, mdo, oe, busy, done} == 5'b0 && rd == 16'h0, "R1 reset state",
        {mdc, mdo, oe, busy, done}, 0);

    // sweep all PHY addresses, both directions
    for (int a = 0; a < 32; a++) begin
      for (int w = 0; w < 2; w++) begin
        resp = 16'((a * 16'h0A31) ^ 16'h5AC3 ^ (w * 16'h0F0F));
        d    = 16'((a * 16'h1357) ^ 16'hC0DE);
        launch(w[0], a[4:0], 5'(31 - a), d, resp);
        finish(w[0], resp, 1'b0);
        after_idle();
      end
    end

    // boundary values with start pulses while busy and in the final cycle
    launch(1'b1, 5'h1F, 5'h00, 16'hFFFF, 16'h0);
    finish(1'b1, 16'h0, 1'b1);
    after_idle();
    launch(1'b0, 5'h00, 5'h1F, 16'h0, 16'h8001);
    finish(1'b0, 16'h8001, 1'b1);
    after_idle();
    launch(1'b0, 5'h15, 5'h0A, 16'h0, 16'hFFFF);
    finish(1'b0, 16'hFFFF, 1'b1);
    after_idle();

    // start during the done cycle is accepted (R9)
    launch(1'b1, 5'h0C, 5'h03, 16'h1234, 16'h0);
    finish(1'b1, 16'h0, 1'b0);
    launch(1'b0, 5'h03, 5'h0C, 16'h0, 16'h0000);
    finish(1'b0, 16'h0000, 1'b0);
    after_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule